// File: doc/BRIEF.md
# Supply Controller Serial Configuration Register

This block is a two-wire serial slave for a supply controller. It holds a single byte of configuration and status. The system clock oversamples the bus lines. The block finds start and stop conditions on the sampled lines. It answers to one 7-bit address, and a 2-bit strap input picks the two low bits of that address. A write transfer carries one data byte. The upper six bits of that byte go into the control bits that drive the power stage.

A read transfer returns a full byte. The upper six bits are the stored control bits. The two low bits are the live state of the over-temperature and overload flags. The slave keeps returning the same byte, rebuilt each time, for as long as the master acknowledges. An undervoltage lockout input holds the register at zero and keeps the slave silent on the bus.

Top module: `supply_ctrl_i2c`

## Requirements
- R1: After reset, `ctrl` is all zeros and `sda_oe` is 0.
- R2: The slave answers only the address `{0001,0, addr_sel}` (binary 00010xx, hex 08 to 0B). After a matching address byte, it pulls SDA low (`sda_oe`=1) during the ninth clock. Address bit 0 is the direction: 0 is write, 1 is read.
- R3: In a write, the data byte's bits 7..2 are stored to `ctrl[5:0]`. Bit 7 goes to `ctrl[5]` and bit 2 goes to `ctrl[0]`. Data bits 1..0 are ignored. The slave acknowledges the data byte.
- R4: A non-matching address is not acknowledged, and the slave does not drive SDA until the next start. Later bytes of that transfer are neither acknowledged nor stored.
- R5: A read byte is `{ctrl[5:0], flag_temp, flag_load}`, sent MSB first. The flag bits are taken from the inputs at the moment each byte begins.
- R6: After a read byte, a master acknowledge (SDA low) makes the slave send a freshly built byte. A master not-acknowledge ends the read with SDA released.
- R7: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. The slave changes its SDA drive only while SCL is low. A stop in the middle of a data byte aborts it, and nothing is stored.
- R8: While `uvlo` is 1, `ctrl` is held at zero and the slave never drives SDA. Once `uvlo` falls, the cleared register reads back as zero.
- R9: A second data byte in the same write transfer is not acknowledged and does not change `ctrl`.
- R10: A repeated start (a start with no stop before it) restarts address matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| addr_sel | input | 2 | Strap for the two low address bits |
| uvlo | input | 1 | Undervoltage lockout, active high |
| flag_temp | input | 1 | Live over-temperature flag (read bit 1) |
| flag_load | input | 1 | Live overload flag (read bit 0) |
| ctrl | output | 6 | Stored control bits (write bits 7..2) |

## Verification
Some situations cannot be set up by a plain sequence of whole transfers. One is the diagnostic flags changing between two read bytes. Another is a transfer that is cut short by a stop, or redirected by a repeated start after a rejected address. The bench drives the bus one bit at a time. This lets it change the flag inputs while the master's acknowledge bit is being set up, which is just before the slave rebuilds its next byte. It also lets the bench issue a stop four bits into a data byte, and a start straight after the ninth clock of a mismatched address. A sweep over all four strap values and six nearby addresses covers address matching. A sweep over all 64 control patterns, with the flags varied, covers the write and read paths.

// File: rtl/supply_ctrl_i2c.sv
module supply_ctrl_i2c #(
  parameter logic [6:0] BASE_ADDR   = 7'h08,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_sel,
  input  logic       uvlo,
  input  logic       flag_temp,
  input  logic       flag_load,
  output logic [5:0] ctrl
);
  localparam int BYTE = 8;
  localparam int CW   = $clog2(BYTE + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK} st_t;

  st_t                  st;
  logic [SYNC_STAGES:0] scl_p, sda_p;
  logic [BYTE-1:0]      sh;
  logic [BYTE-2:0]      tx;
  logic [CW-1:0]        cnt;
  logic                 rw, mack;

  wire scl_s = scl_p[SYNC_STAGES-1];
  wire scl_q = scl_p[SYNC_STAGES];
  wire sda_s = sda_p[SYNC_STAGES-1];
  wire sda_q = sda_p[SYNC_STAGES];

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire full     = (cnt == CW'(BYTE));
  wire match    = (sh[7:1] == {BASE_ADDR[6:2], addr_sel});

  wire [BYTE-1:0] rd_word = {ctrl, flag_temp, flag_load};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      sh     <= '0;
      tx     <= '0;
      cnt    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      ctrl   <= '0;
    end else if (uvlo) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
      ctrl   <= '0;
    end else if (start_c) begin
      st     <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR:
          if (scl_rise) begin
            sh  <= {sh[BYTE-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && full) begin
            if (match) begin
              rw     <= sh[0];
              sda_oe <= 1'b1;
              st     <= S_AACK;
            end else begin
              st <= S_IDLE;
            end
          end
        S_AACK:
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx     <= rd_word[BYTE-2:0];
              sda_oe <= ~rd_word[BYTE-1];
              st     <= S_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WDAT;
            end
          end
        S_WDAT:
          if (scl_rise) begin
            sh  <= {sh[BYTE-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && full) begin
            ctrl   <= sh[BYTE-1:2];
            sda_oe <= 1'b1;
            st     <= S_WACK;
          end
        S_WACK:
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_IDLE;
          end
        S_RDAT:
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (full) begin
              sda_oe <= 1'b0;
              st     <= S_RACK;
            end else begin
              sda_oe <= ~tx[BYTE-2];
              tx     <= {tx[BYTE-3:0], 1'b0};
            end
          end
        S_RACK:
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              cnt    <= '0;
              tx     <= rd_word[BYTE-2:0];
              sda_oe <= ~rd_word[BYTE-1];
              st     <= S_RDAT;
            end else begin
              st <= S_IDLE;
            end
          end
        default: ;
      endcase
    end

  p_uvlo_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (ctrl == '0 && !sda_oe));

  p_sda_low_phase_r7: assert property (@(posedge clk) disable iff (!rst_n || uvlo)
    !$stable(sda_oe) |-> !scl_s);

  p_ctrl_on_ack_edge_r3: assert property (@(posedge clk) disable iff (!rst_n || uvlo)
    !$stable(ctrl) |-> (!scl_s && sda_oe));

  p_release_for_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK) |-> !sda_oe);

  p_idle_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
endmodule

// File: tb/sim_supply_ctrl_i2c.sv
module sim_supply_ctrl_i2c;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic       uvlo = 1'b0, flag_temp = 1'b0, flag_load = 1'b0;
  logic       sda_oe;
  logic [5:0] ctrl;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  wire sda_bus = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  supply_ctrl_i2c u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .uvlo(uvlo), .flag_temp(flag_temp), .flag_load(flag_load),
    .ctrl(ctrl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic i_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input bit b);
    m_sda = b;    wq(Q);
    m_scl = 1'b1; wq(2 * Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_bit(output bit b);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    b = sda_bus;  wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rbits(output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, output bit ak, output bit dk);
    i_start();
    wbyte({a, 1'b0}, ak);
    wbyte(d, dk);
    i_stop();
  endtask

  task automatic do_read(input logic [6:0] a, output bit ak, output logic [7:0] v);
    i_start();
    wbyte({a, 1'b1}, ak);
    rbits(v);
    send_bit(1'b1);
    i_stop();
  endtask

  initial begin
    bit ak, dk, dk2;
    logic [7:0] v1, v2, v3;
    logic [5:0] exp_c;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    chk("R1 ctrl after reset", ctrl, 0);
    chk("R1 sda released after reset", sda_oe, 0);

    exp_c = '0;
    for (int sel = 0; sel < 4; sel++) begin
      for (int c = 0; c < 6; c++) begin
        logic [7:0] d;
        addr_sel = sel[1:0];
        d = {c[2:0], sel[1:0], 1'b1, 2'b10};
        do_write(7'h08 + 7'(c), d, ak, dk);
        if (c == sel) exp_c = d[7:2];
        chk("R2 address acknowledge", ak, (c == sel));
        chk("R4 data ack only after match", dk, (c == sel));
        chk("R4 ctrl after address sweep", ctrl, exp_c);
      end
    end
    addr_sel = 2'd3;
    do_write(7'h1B, 8'hFC, ak, dk);
    chk("R4 upper address bits differ", ak, 0);
    chk("R4 ctrl unchanged on mismatch", ctrl, exp_c);

    addr_sel = 2'd1;
    i_start();
    wbyte({7'h09, 1'b0}, ak);
    wbyte(8'hA4, dk);
    wbyte(8'h58, dk2);
    i_stop();
    chk("R3 first byte acknowledged", dk, 1);
    chk("R9 second byte not acknowledged", dk2, 0);
    chk("R9 ctrl keeps first byte", ctrl, 6'h29);

    i_start();
    wbyte({7'h0A, 1'b0}, ak);
    chk("R4 wrong address before repeated start", ak, 0);
    i_start();
    wbyte({7'h09, 1'b0}, ak);
    wbyte(8'h3C, dk);
    i_stop();
    chk("R10 repeated start address ack", ak, 1);
    chk("R10 write after repeated start", ctrl, 6'h0F);

    i_start();
    wbyte({7'h09, 1'b0}, ak);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i_stop();
    chk("R7 stop mid-byte stores nothing", ctrl, 6'h0F);
    chk("R7 slave released after abort", sda_oe, 0);
    do_write(7'h09, 8'hC8, ak, dk);
    chk("R7 next write after abort", ctrl, 6'h32);

    flag_temp = 1'b1; flag_load = 1'b0;
    i_start();
    wbyte({7'h09, 1'b1}, ak);
    rbits(v1);
    flag_temp = 1'b0; flag_load = 1'b1;
    send_bit(1'b0);
    rbits(v2);
    send_bit(1'b0);
    rbits(v3);
    send_bit(1'b1);
    chk("R6 released after master nack", sda_oe, 0);
    i_stop();
    chk("R5 first read byte", v1, 8'hCA);
    chk("R6 repeated byte with new flags", v2, 8'hC9);
    chk("R6 third byte", v3, 8'hC9);

    do_write(7'h09, 8'hFC, ak, dk);
    chk("R3 all control bits set", ctrl, 6'h3F);
    uvlo = 1'b1;
    wq(4);
    chk("R8 lockout clears register", ctrl, 0);
    do_write(7'h09, 8'hFC, ak, dk);
    chk("R8 no acknowledge in lockout", ak, 0);
    chk("R8 register stays cleared", ctrl, 0);
    uvlo = 1'b0;
    wq(4);
    flag_temp = 1'b1; flag_load = 1'b1;
    do_read(7'h09, ak, v1);
    chk("R8 ack after lockout ends", ak, 1);
    chk("R8 readback after lockout", v1, 8'h03);

    addr_sel = 2'd2;
    for (int v = 0; v < 64; v++) begin
      logic [7:0] d;
      d = {v[5:0], ~v[1:0]};
      flag_temp = v[3];
      flag_load = v[0];
      do_write(7'h0A, d, ak, dk);
      chk("R3 write acknowledge", dk, 1);
      chk("R3 stored control bits", ctrl, v);
      do_read(7'h0A, ak, v1);
      chk("R5 read acknowledge", ak, 1);
      chk("R5 read word", v1, {v[5:0], v[3], v[0]});
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wq(190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule